// File: doc/BRIEF.md
# LED and DMD Power Enable Sequencer

This block sits between a projector's color sequence engine and the external LED driver and DMD regulator. It owns four kinds of output. The first is a master LED driver enable. The second is a two-bit LED color select. The third is three per-color PWM lines. The fourth is the enable for the DMD bias and reset regulators.

It takes an asynchronous LED enable and an asynchronous active-low park request. Each one passes through a two-flop synchronizer. The block then applies an asymmetric timing policy to them. Turning the LEDs on waits a long, parameterized delay. Turning them off is as fast as the synchronizer allows.

The regulator enable follows park immediately when park is released. When park is asserted, the regulator enable is held on for a parameterized hold-off before it drops.

The select code and the PWM levels come from the sequence engine and are registered through the block. While the master enable is off, the select is forced to "none". While the master enable is off, software LED control is off, or the sequence is stopped, every PWM line is forced high.

Top module: `led_pwr_seq`

## Requirements
- R1: With the synchronized park request high, `drv_on_o` rises exactly ON_DELAY_CYC+1 clock edges after the first edge that samples `led_en_i` high. Before that it stays low.
- R2: `drv_on_o` falls at the third clock edge (edge index 2) after the first edge that samples either `led_en_i` low or `park_n_i` low.
- R3: If `led_en_i` or `park_n_i` drops during the turn-on delay, the delay count is discarded. A later enable waits the full ON_DELAY_CYC+1 edges again.
- R4: While the driver is on, `sel_o` equals `sel_req_i` one edge later. The codes pass unchanged: 00 none, 01 red, 10 green, 11 blue. Whenever `drv_on_o` is low, `sel_o` is 00.
- R5: `pwm_o` equals `pwm_req_i` one edge later only when the driver is on, `sw_ctrl_i` is high and `seq_run_i` is high. Otherwise `pwm_o` is 3'b111. Bit 0 is red, bit 1 green and bit 2 blue.
- R6: `dmd_pwr_o` rises at edge index 2 after the first edge that samples `park_n_i` high.
- R7: After `park_n_i` is sampled low, `dmd_pwr_o` stays high and falls exactly at edge index PARK_HOLD_CYC+1.
- R8: If `park_n_i` returns high during the hold-off, `dmd_pwr_o` never drops. A later park request waits the full hold-off again.
- R9: Reset drives `drv_on_o`, `sel_o` and `dmd_pwr_o` low and `pwm_o` to 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| led_en_i | input | 1 | Asynchronous LED enable request |
| park_n_i | input | 1 | Asynchronous park request, active low |
| sel_req_i | input | 2 | Color select requested by the sequence engine |
| sw_ctrl_i | input | 1 | Software LED control active |
| seq_run_i | input | 1 | Color sequence running |
| pwm_req_i | input | 3 | Per-color PWM requests (blue, green, red) |
| drv_on_o | output | 1 | Master LED driver enable |
| sel_o | output | 2 | LED color select to the driver |
| pwm_o | output | 3 | Per-color PWM outputs (blue, green, red) |
| dmd_pwr_o | output | 1 | DMD power regulator enable |

## Verification
The bench sweeps edge by edge across the turn-on delay and the park hold-off. An off-by-one counter would move the transition one sample early or late. It aborts the turn-on delay midway and re-arms it, so a counter that is not cleared would turn the driver on too soon. It returns park during the hold-off, which catches a design that lets the regulator enable glitch low or carries the old hold count into the next request. It also walks every select code and every combination of the PWM requests, software control and sequence-run flags, which exposes a wrong forcing value or a swapped bit.

// File: rtl/led_pwr_pkg.sv
package led_pwr_pkg;
  typedef enum logic [1:0] {
    LED_NONE  = 2'b00,
    LED_RED   = 2'b01,
    LED_GREEN = 2'b10,
    LED_BLUE  = 2'b11
  } led_sel_e;

  localparam int unsigned NUM_COLORS = 3;
  localparam logic [NUM_COLORS-1:0] PWM_FORCED = '1;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/asym_delay.sv
// Level follower with a counted delay on one edge only.
// DELAY_RISE=1: rise after CYC edges, fall at once.
// DELAY_RISE=0: rise at once, fall after CYC edges.
module asym_delay #(
  parameter int unsigned CYC        = 16,
  parameter bit          DELAY_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic q_o,
  output logic nxt_o
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  generate
    if (DELAY_RISE) begin : g_rise
      always_comb begin
        nxt_o = lvl_i && (q_o || at_last);
        cnt_d = (!lvl_i || q_o) ? '0 : cnt_q + 1'b1;
      end

      // R1
      early_on_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_i && !q_o && !at_last) |=> !q_o);
    end else begin : g_fall
      always_comb begin
        nxt_o = lvl_i || (q_o && !at_last);
        cnt_d = (lvl_i || !q_o) ? '0 : cnt_q + 1'b1;
      end

      // R7
      hold_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!lvl_i && q_o && !at_last) |=> q_o);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_o   <= nxt_o;
    end
  end
endmodule

// File: rtl/led_pwr_seq.sv
module led_pwr_seq
  import led_pwr_pkg::*;
#(
  parameter int unsigned ON_DELAY_CYC  = 5_000_000,
  parameter int unsigned PARK_HOLD_CYC = 25_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  led_en_i,
  input  logic                  park_n_i,
  input  logic [1:0]            sel_req_i,
  input  logic                  sw_ctrl_i,
  input  logic                  seq_run_i,
  input  logic [NUM_COLORS-1:0] pwm_req_i,
  output logic                  drv_on_o,
  output logic [1:0]            sel_o,
  output logic [NUM_COLORS-1:0] pwm_o,
  output logic                  dmd_pwr_o
);
  logic [1:0] sync_q;
  logic       s_en, s_park;
  logic       drv_nxt, dmd_nxt;
  logic       pwm_pass;

  sync2 #(.WIDTH(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({park_n_i, led_en_i}),
    .q_o (sync_q)
  );

  assign s_en   = sync_q[0];
  assign s_park = sync_q[1];

  asym_delay #(.CYC(ON_DELAY_CYC), .DELAY_RISE(1'b1)) i_drv_dly (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (s_en && s_park),
    .q_o   (drv_on_o),
    .nxt_o (drv_nxt)
  );

  asym_delay #(.CYC(PARK_HOLD_CYC), .DELAY_RISE(1'b0)) i_dmd_hold (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (s_park),
    .q_o   (dmd_pwr_o),
    .nxt_o (dmd_nxt)
  );

  assign pwm_pass = drv_nxt && sw_ctrl_i && seq_run_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o <= LED_NONE;
      pwm_o <= PWM_FORCED;
    end else begin
      sel_o <= drv_nxt ? sel_req_i : LED_NONE;
      pwm_o <= pwm_pass ? pwm_req_i : PWM_FORCED;
    end
  end

  // R2
  drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!s_en || !s_park) |=> !drv_on_o);

  // R4
  sel_forced_chk: assert property (@(posedge clk) disable iff (rst)
    !drv_on_o |-> (sel_o == LED_NONE));

  // R5
  pwm_forced_chk: assert property (@(posedge clk) disable iff (rst)
    !drv_on_o |-> (pwm_o == PWM_FORCED));

  // R6
  dmd_on_chk: assert property (@(posedge clk) disable iff (rst)
    s_park |=> dmd_pwr_o);

  // R8
  dmd_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dmd_pwr_o && s_park) |=> dmd_pwr_o);
endmodule

// File: tb/test_led_pwr_seq.sv
`timescale 1ns/1ps
module test_led_pwr_seq;
  localparam int D = 12;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic       led_en, park_n, sw_ctrl, seq_run;
  logic [1:0] sel_req;
  logic [2:0] pwm_req;
  logic       drv_on, dmd_pwr;
  logic [1:0] sel;
  logic [2:0] pwm;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  led_pwr_seq #(.ON_DELAY_CYC(D), .PARK_HOLD_CYC(H)) i_led_pwr_seq (
    .clk       (clk),
    .rst       (rst),
    .led_en_i  (led_en),
    .park_n_i  (park_n),
    .sel_req_i (sel_req),
    .sw_ctrl_i (sw_ctrl),
    .seq_run_i (seq_run),
    .pwm_req_i (pwm_req),
    .drv_on_o  (drv_on),
    .sel_o     (sel),
    .pwm_o     (pwm),
    .dmd_pwr_o (dmd_pwr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  // Turn-on sweep: after j ticks the sample follows edge j-1; on at edge D+1.
  task automatic on_sweep(input string req);
    led_en = 1'b1;
    for (int j = 1; j <= D + 4; j++) begin
      tick();
      chk(req, drv_on, (j >= D + 2) ? 1 : 0);
    end
  endtask

  initial begin
    rst = 1'b1; led_en = 0; park_n = 0; sw_ctrl = 0; seq_run = 0;
    sel_req = 2'b11; pwm_req = 3'b000;
    repeat (3) tick();
    // R9 reset state
    chk("R9 drv", drv_on, 0);
    chk("R9 sel", sel, 0);
    chk("R9 pwm", pwm, 7);
    chk("R9 dmd", dmd_pwr, 0);
    rst = 1'b0;

    // R6 regulator turn-on: high at edge 2
    park_n = 1'b1;
    for (int j = 1; j <= 5; j++) begin
      tick();
      chk("R6", dmd_pwr, (j >= 3) ? 1 : 0);
    end

    // R1 full delay
    on_sweep("R1");

    // R4 select codes 00 none, 01 red, 10 green, 11 blue
    for (int s = 0; s < 4; s++) begin
      sel_req = 2'(s);
      tick();
      chk("R4 pass", sel, s);
    end

    // R5 all combinations with driver on
    for (int m = 0; m < 32; m++) begin
      sw_ctrl = m[4]; seq_run = m[3]; pwm_req = m[2:0];
      tick();
      chk("R5 on", pwm, (m[4] && m[3]) ? m[2:0] : 7);
    end

    // R2 turn-off via led_en, edge 2
    sw_ctrl = 1; seq_run = 1; pwm_req = 3'b010; sel_req = 2'b10;
    led_en = 1'b0;
    for (int j = 1; j <= 5; j++) begin
      tick();
      chk("R2 en", drv_on, (j < 3) ? 1 : 0);
    end
    chk("R4 forced", sel, 0);
    chk("R5 forced", pwm, 7);

    // R3 abort midway, then full delay again
    led_en = 1'b1;
    repeat (D / 2) tick();
    chk("R3 mid", drv_on, 0);
    led_en = 1'b0;
    repeat (4) tick();
    on_sweep("R3");

    // R2 via park, and R7 hold-off sweep
    park_n = 1'b0;
    for (int j = 1; j <= H + 4; j++) begin
      tick();
      chk("R2 park", drv_on, (j < 3) ? 1 : 0);
      chk("R7", dmd_pwr, (j < H + 2) ? 1 : 0);
    end

    // R8 park returns during hold
    park_n = 1'b1;
    repeat (4) tick();
    park_n = 1'b0;
    repeat (H - 2) tick();
    chk("R8 mid", dmd_pwr, 1);
    park_n = 1'b1;
    for (int j = 1; j <= 4; j++) begin
      tick();
      chk("R8 kept", dmd_pwr, 1);
    end
    park_n = 1'b0;
    for (int j = 1; j <= H + 3; j++) begin
      tick();
      chk("R8 full", dmd_pwr, (j < H + 2) ? 1 : 0);
    end

    // R3 re-enable after park: full delay again
    park_n = 1'b1;
    on_sweep("R3 park");

    finish_run();
  end
endmodule